// File: doc/BRIEF.md
# Second-Level Cache Enable Sequencer

This block is a control state machine that brings a second-level cache from off to on in a safe order after power-up. A single start pulse launches it. It first reads a features register and, when prefetch is not yet disabled, writes the register back with the prefetch-disable bit set. It then reads the register again. If the cache-enable bit is already set, it stops and reports a fault. Otherwise it flushes and turns off the first-level data cache and turns off and invalidates the first-level instruction cache. It invalidates the whole second-level cache and writes the enable bit. Last, it turns the first-level caches back on, but only those that were on when the sequence started.

All traffic goes through two request/acknowledge ports. The feature port carries register reads and writes. The maintenance port carries one operation code per step. Each request stays up until its acknowledge arrives. When the sequence ends, the block pulses `done_o` for one cycle. `fault_o` then shows whether the cache was found already enabled.

Top module: `cache_en_seq`

## Requirements
- R1: After reset, `feat_req_o`, `mnt_req_o`, `done_o` and `fault_o` are all low.
- R2: A start pulse while idle begins the sequence with a feature read (`feat_we_o`=0). The levels of `l1d_on_i` and `l1i_on_i` are captured in that same cycle. A start pulse while a sequence runs has no effect.
- R3: If bit PF_BIT (default 24) of the first read value is 0, the next step writes that value with bit PF_BIT set. If the bit is 1, no write is made. Every feature write has bit PF_BIT set.
- R4: After the prefetch step, the features register is read a second time. If bit EN_BIT (default 22) of that value is 1, no maintenance operation and no further write is issued, and the sequence ends with `fault_o`=1.
- R5: If the data cache was on at start, operation 0 (flush whole L1 data cache) is issued, then operation 1 (L1 data cache off). Both come before any instruction-cache operation.
- R6: If the instruction cache was on at start, operation 2 (L1 instruction cache off) is issued, then operation 3 (invalidate whole L1 instruction cache).
- R7: After the first-level steps, operation 4 (invalidate whole L2) is issued. It is followed by a feature write of the second read value with bit EN_BIT and bit PF_BIT set.
- R8: After the enable write, operation 5 (L1 instruction cache on) is issued if the instruction cache was on at start. Then operation 6 (L1 data cache on) is issued if the data cache was on at start.
- R9: At most one request is raised at a time. A request and its opcode or write data hold steady until the acknowledge is seen.
- R10: The end of every sequence gives a one-cycle `done_o` pulse. `fault_o` is valid from that cycle and holds until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| l1d_on_i | input | 1 | L1 data cache is currently enabled |
| l1i_on_i | input | 1 | L1 instruction cache is currently enabled |
| feat_req_o | output | 1 | Feature register access request |
| feat_we_o | output | 1 | 1 = write, 0 = read |
| feat_wdata_o | output | FEAT_W | Feature write data |
| feat_rdata_i | input | FEAT_W | Feature read data, sampled with the acknowledge |
| feat_ack_i | input | 1 | Feature access acknowledge |
| mnt_req_o | output | 1 | Maintenance operation request |
| mnt_op_o | output | 3 | Maintenance operation code (0..6) |
| mnt_ack_i | input | 1 | Maintenance acknowledge |
| done_o | output | 1 | Sequence finished (one cycle) |
| fault_o | output | 1 | Cache was found already enabled |

## Verification
The bench builds the block with its defaults: a 32-bit features register, prefetch-disable at bit 24 and enable at bit 22. It runs all sixteen combinations of prefetch bit, enable bit and the two first-level enable levels. Each combination runs at two acknowledge latencies. This covers every skip path through the sequence and both the fault and normal endings. For every combination, the bench derives the ordered list of register accesses and operation codes, and the expected write data, by arithmetic. It also fires a second start in the middle of the longest sequences.

// File: rtl/cen_pkg.sv
package cen_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PF_RD, ST_PF_WR, ST_EN_RD,
    ST_D_CLEAN, ST_D_OFF, ST_I_OFF, ST_I_INV,
    ST_L2_INV, ST_EN_WR, ST_I_ON, ST_D_ON, ST_FIN
  } seq_st_e;

  typedef enum logic [2:0] {
    OP_D_CLEAN = 3'd0,
    OP_D_OFF   = 3'd1,
    OP_I_OFF   = 3'd2,
    OP_I_INV   = 3'd3,
    OP_L2_INV  = 3'd4,
    OP_I_ON    = 3'd5,
    OP_D_ON    = 3'd6,
    OP_NONE    = 3'd7
  } mnt_op_e;

endpackage

// File: rtl/cen_seq_fsm.sv
module cen_seq_fsm
  import cen_pkg::*;
#(
  parameter int FEAT_W = 32,
  parameter int PF_BIT = 24,
  parameter int EN_BIT = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              d_was_on_i,
  input  logic              i_was_on_i,
  input  logic [FEAT_W-1:0] feat_rdata_i,
  input  logic              feat_ack_i,
  input  logic              mnt_ack_i,
  output seq_st_e           state_o,
  output logic              accept_o,
  output logic              fault_o
);

  seq_st_e st_q, st_d;
  logic    flt_set, flt_en, flt_d;

  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign flt_set  = (st_q == ST_EN_RD) && feat_ack_i && feat_rdata_i[EN_BIT];
  assign flt_en   = accept_o || flt_set;
  assign flt_d    = flt_set;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_i) st_d = ST_PF_RD;
      ST_PF_RD:   if (feat_ack_i) st_d = feat_rdata_i[PF_BIT] ? ST_EN_RD : ST_PF_WR;
      ST_PF_WR:   if (feat_ack_i) st_d = ST_EN_RD;
      ST_EN_RD:
        if (feat_ack_i) begin
          if (feat_rdata_i[EN_BIT]) st_d = ST_FIN;
          else if (d_was_on_i)      st_d = ST_D_CLEAN;
          else if (i_was_on_i)      st_d = ST_I_OFF;
          else                      st_d = ST_L2_INV;
        end
      ST_D_CLEAN: if (mnt_ack_i) st_d = ST_D_OFF;
      ST_D_OFF:   if (mnt_ack_i) st_d = i_was_on_i ? ST_I_OFF : ST_L2_INV;
      ST_I_OFF:   if (mnt_ack_i) st_d = ST_I_INV;
      ST_I_INV:   if (mnt_ack_i) st_d = ST_L2_INV;
      ST_L2_INV:  if (mnt_ack_i) st_d = ST_EN_WR;
      ST_EN_WR:
        if (feat_ack_i) begin
          if (i_was_on_i)      st_d = ST_I_ON;
          else if (d_was_on_i) st_d = ST_D_ON;
          else                 st_d = ST_FIN;
        end
      ST_I_ON:    if (mnt_ack_i) st_d = d_was_on_i ? ST_D_ON : ST_FIN;
      ST_D_ON:    if (mnt_ack_i) st_d = ST_FIN;
      ST_FIN:     st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fault_o <= 1'b0;
    else if (flt_en) fault_o <= flt_d;
  end

  assign state_o = st_q;

  // R2: the first read step is only entered from idle
  a_r2_entry_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PF_RD && $past(st_q) != ST_PF_RD) |-> $past(st_q) == ST_IDLE);

  // R4: a fault is raised only while heading for the finish state
  a_r4_fault_to_fin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> st_q == ST_FIN);

  // R7: the enable write is reached only through the L2 invalidate
  a_r7_l2_before_en: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EN_WR && $past(st_q) != ST_EN_WR) |-> $past(st_q) == ST_L2_INV);

endmodule

// File: rtl/cen_snap.sv
module cen_snap
  import cen_pkg::*;
#(
  parameter int FEAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              l1d_on_i,
  input  logic              l1i_on_i,
  input  seq_st_e           state_i,
  input  logic              feat_ack_i,
  input  logic [FEAT_W-1:0] feat_rdata_i,
  output logic              d_was_on_o,
  output logic              i_was_on_o,
  output logic [FEAT_W-1:0] feat_val_o
);

  logic rd_cap;
  assign rd_cap = feat_ack_i && (state_i == ST_PF_RD || state_i == ST_EN_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_was_on_o <= 1'b0;
      i_was_on_o <= 1'b0;
    end else if (accept_i) begin
      d_was_on_o <= l1d_on_i;
      i_was_on_o <= l1i_on_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      feat_val_o <= '0;
    else if (rd_cap) feat_val_o <= feat_rdata_i;
  end

endmodule

// File: rtl/cen_ports.sv
module cen_ports
  import cen_pkg::*;
#(
  parameter int FEAT_W = 32,
  parameter int PF_BIT = 24,
  parameter int EN_BIT = 22
) (
  input  seq_st_e           state_i,
  input  logic [FEAT_W-1:0] feat_val_i,
  output logic              feat_req_o,
  output logic              feat_we_o,
  output logic [FEAT_W-1:0] feat_wdata_o,
  output logic              mnt_req_o,
  output mnt_op_e           mnt_op_o,
  output logic              done_o
);

  localparam logic [FEAT_W-1:0] PF_MASK = FEAT_W'(1) << PF_BIT;
  localparam logic [FEAT_W-1:0] EN_MASK = FEAT_W'(1) << EN_BIT;

  always_comb begin
    feat_req_o   = 1'b0;
    feat_we_o    = 1'b0;
    feat_wdata_o = '0;
    mnt_req_o    = 1'b1;
    mnt_op_o     = OP_NONE;
    done_o       = 1'b0;
    unique case (state_i)
      ST_PF_RD, ST_EN_RD: begin
        feat_req_o = 1'b1;
        mnt_req_o  = 1'b0;
      end
      ST_PF_WR: begin
        feat_req_o   = 1'b1;
        feat_we_o    = 1'b1;
        feat_wdata_o = feat_val_i | PF_MASK;
        mnt_req_o    = 1'b0;
      end
      ST_EN_WR: begin
        feat_req_o   = 1'b1;
        feat_we_o    = 1'b1;
        feat_wdata_o = feat_val_i | PF_MASK | EN_MASK;
        mnt_req_o    = 1'b0;
      end
      ST_D_CLEAN: mnt_op_o = OP_D_CLEAN;
      ST_D_OFF:   mnt_op_o = OP_D_OFF;
      ST_I_OFF:   mnt_op_o = OP_I_OFF;
      ST_I_INV:   mnt_op_o = OP_I_INV;
      ST_L2_INV:  mnt_op_o = OP_L2_INV;
      ST_I_ON:    mnt_op_o = OP_I_ON;
      ST_D_ON:    mnt_op_o = OP_D_ON;
      ST_FIN: begin
        done_o    = 1'b1;
        mnt_req_o = 1'b0;
      end
      default:    mnt_req_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cache_en_seq.sv
module cache_en_seq
  import cen_pkg::*;
#(
  parameter int FEAT_W = 32,
  parameter int PF_BIT = 24,
  parameter int EN_BIT = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              l1d_on_i,
  input  logic              l1i_on_i,
  output logic              feat_req_o,
  output logic              feat_we_o,
  output logic [FEAT_W-1:0] feat_wdata_o,
  input  logic [FEAT_W-1:0] feat_rdata_i,
  input  logic              feat_ack_i,
  output logic              mnt_req_o,
  output logic [2:0]        mnt_op_o,
  input  logic              mnt_ack_i,
  output logic              done_o,
  output logic              fault_o
);

  seq_st_e           state;
  logic              accept, d_was_on, i_was_on;
  logic [FEAT_W-1:0] feat_val;
  mnt_op_e           op;

  cen_seq_fsm #(.FEAT_W(FEAT_W), .PF_BIT(PF_BIT), .EN_BIT(EN_BIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .d_was_on_i(d_was_on), .i_was_on_i(i_was_on),
    .feat_rdata_i(feat_rdata_i), .feat_ack_i(feat_ack_i), .mnt_ack_i(mnt_ack_i),
    .state_o(state), .accept_o(accept), .fault_o(fault_o)
  );

  cen_snap #(.FEAT_W(FEAT_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .accept_i(accept),
    .l1d_on_i(l1d_on_i), .l1i_on_i(l1i_on_i), .state_i(state),
    .feat_ack_i(feat_ack_i), .feat_rdata_i(feat_rdata_i),
    .d_was_on_o(d_was_on), .i_was_on_o(i_was_on), .feat_val_o(feat_val)
  );

  cen_ports #(.FEAT_W(FEAT_W), .PF_BIT(PF_BIT), .EN_BIT(EN_BIT)) u_ports (
    .state_i(state), .feat_val_i(feat_val),
    .feat_req_o(feat_req_o), .feat_we_o(feat_we_o), .feat_wdata_o(feat_wdata_o),
    .mnt_req_o(mnt_req_o), .mnt_op_o(op), .done_o(done_o)
  );

  assign mnt_op_o = op;

  // R9: requests hold with stable payload until acknowledged
  a_r9_feat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_req_o && !feat_ack_i) |=> (feat_req_o && $stable(feat_we_o) && $stable(feat_wdata_o)));
  a_r9_mnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_req_o && !mnt_ack_i) |=> (mnt_req_o && $stable(mnt_op_o)));
  a_r9_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(feat_req_o && mnt_req_o));

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: every feature write carries the prefetch-disable bit
  a_r3_pf_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_req_o && feat_we_o) |-> feat_wdata_o[PF_BIT]);

endmodule

// File: tb/cache_en_seq_tb_top.sv
module cache_en_seq_tb_top;

  localparam int W = 32;
  localparam logic [W-1:0] PFM = 32'h0100_0000;
  localparam logic [W-1:0] ENM = 32'h0040_0000;
  localparam int EV_RD = 16;
  localparam int EV_WR = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic start, l1d_on, l1i_on;
  logic feat_req, feat_we, feat_ack, mnt_req, mnt_ack, done, fault;
  logic [W-1:0] feat_wdata, feat_model;
  logic [2:0] mnt_op;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  int tlen   = 0;
  int wlen   = 0;
  int trace [0:31];
  logic [W-1:0] wlog [0:7];

  always #5 clk = ~clk;

  cache_en_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .l1d_on_i(l1d_on), .l1i_on_i(l1i_on),
    .feat_req_o(feat_req), .feat_we_o(feat_we), .feat_wdata_o(feat_wdata),
    .feat_rdata_i(feat_model), .feat_ack_i(feat_ack),
    .mnt_req_o(mnt_req), .mnt_op_o(mnt_op), .mnt_ack_i(mnt_ack),
    .done_o(done), .fault_o(fault)
  );

  // Responder: acknowledge after lat idle negedges, log each completed step
  always @(negedge clk) begin
    if (feat_ack || mnt_ack) begin
      feat_ack = 1'b0;
      mnt_ack  = 1'b0;
      wcnt     = 0;
    end else if (feat_req || mnt_req) begin
      if (wcnt >= lat) begin
        if (tlen < 32) begin
          trace[tlen] = feat_req ? (feat_we ? EV_WR : EV_RD) : int'(mnt_op);
          tlen++;
        end
        if (feat_req) begin
          feat_ack = 1'b1;
          if (feat_we) begin
            if (wlen < 8) wlog[wlen] = feat_wdata;
            wlen++;
            feat_model = feat_wdata;
          end
        end else begin
          mnt_ack = 1'b1;
        end
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input bit pf, input bit en, input bit d, input bit i,
                          input int l, input bit poke);
    int exp [0:31];
    int elen = 0;
    int t = 0;
    int dones = 0;
    logic [W-1:0] orig, w1, w2;
    orig = (32'h1234_5678 ^ {28'd0, pf, en, d, i}) & ~(PFM | ENM);
    if (pf) orig = orig | PFM;
    if (en) orig = orig | ENM;
    lat = l;
    feat_model = orig;
    l1d_on = d;
    l1i_on = i;
    tlen = 0;
    wlen = 0;
    // expected step list
    exp[elen++] = EV_RD;
    if (!pf) exp[elen++] = EV_WR;
    exp[elen++] = EV_RD;
    if (!en) begin
      if (d) begin exp[elen++] = 0; exp[elen++] = 1; end
      if (i) begin exp[elen++] = 2; exp[elen++] = 3; end
      exp[elen++] = 4;
      exp[elen++] = EV_WR;
      if (i) exp[elen++] = 5;
      if (d) exp[elen++] = 6;
    end
    w1 = orig | PFM;
    w2 = orig | PFM | ENM;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    l1d_on = ~d;
    l1i_on = ~i;
    chk(fault == 1'b0, "R10 fault cleared on start", fault, 0);
    chk(feat_req && !feat_we, "R2 first step is a read", {feat_req, feat_we}, 2);
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, "R10 done reached", done, 1);
    chk(fault == en, "R4 fault flag", fault, en);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
    chk(!feat_req && !mnt_req, "R9 ports idle after done", {feat_req, mnt_req}, 0);
    repeat (3) @(negedge clk);
    chk(fault == en, "R10 fault held", fault, en);
    chk(tlen == elen, "R2/R4 step count", tlen, elen);
    for (int k = 0; k < elen && k < tlen; k++) begin
      if (exp[k] < EV_RD) begin
        if (exp[k] <= 1)      chk(trace[k] == exp[k], "R5 data cache step", trace[k], exp[k]);
        else if (exp[k] <= 3) chk(trace[k] == exp[k], "R6 instr cache step", trace[k], exp[k]);
        else if (exp[k] == 4) chk(trace[k] == exp[k], "R7 L2 invalidate step", trace[k], exp[k]);
        else                  chk(trace[k] == exp[k], "R8 restore step", trace[k], exp[k]);
      end else begin
        chk(trace[k] == exp[k], "R3 register access kind", trace[k], exp[k]);
      end
    end
    if (!pf) chk(wlen >= 1 && wlog[0] == w1, "R3 prefetch write data", wlog[0], w1);
    if (!en) chk(wlen >= 1 && wlog[wlen-1] == w2, "R7 enable write data", wlog[wlen-1], w2);
    if (en)  chk(wlen == (pf ? 0 : 1), "R4 no enable write", wlen, pf ? 0 : 1);
    dones = 0;
    repeat (6) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk(dones == 0, "R2 busy start ignored", dones, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    l1d_on = 1'b0;
    l1i_on = 1'b0;
    feat_ack = 1'b0;
    mnt_ack = 1'b0;
    feat_model = '0;
    repeat (3) @(negedge clk);
    chk({feat_req, mnt_req, done, fault} == 4'b0, "R1 reset state",
        {feat_req, mnt_req, done, fault}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({feat_req, mnt_req, done, fault} == 4'b0, "R1 idle after reset",
        {feat_req, mnt_req, done, fault}, 0);
    for (int l = 0; l <= 2; l += 2)
      for (int c = 0; c < 16; c++)
        run_case(c[3], c[2], c[1], c[0], l, (l == 2) && !c[2]);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule